// File: doc/BRIEF.md
# Two-Bank Interleaved Row/Column Memory Controller

This block fronts a small storage array that is organised like dynamic memory: two banks, each holding rows of column words, with one row-wide sense latch per bank. A requester presents a read or a write on a valid/ready port. The controller splits the address into bank, row and column fields. It opens the row into the bank's sense latch, performs one or more column accesses on that latch, and then writes the row back. After a row closes, that bank must rest for a fixed recovery time. The bank-select bit is the lowest address bit, so a stream of sequential addresses lands in alternate banks and one bank recovers while the other works.

Reads may be bursts: the requester gives only the first address and a two-bit length code. An internal column counter walks the following columns of the open row and wraps within it. Read beats return through a fixed-latency pipe, in order. A free-running interval timer requests periodic refresh of one row at a time. A pending refresh waits for the current access to finish, then blocks new requests until it has opened and rewritten its row. Its target counter steps through every row of both banks.

Top module: `dram_ilv_ctrl`

## Requirements
- R1: After reset, req_ready is high for every address, rd_valid is low and every stored word reads as zero.
- R2: Address bit 0 selects the bank, bits COL_W:1 select the column and the remaining upper bits select the row; the same row and column in bank 0 and bank 1 are distinct words.
- R3: A request is accepted on a rising edge where req_valid and req_ready are both high. The row opens in the next cycle and the first column select follows it. Each read beat raises rd_valid RD_LAT cycles after its column select, so the first beat is presented after the fourth rising edge, counting the accepting edge as the first (RD_LAT = 2).
- R4: For reads, req_blen codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats on consecutive cycles. The column starts at the addressed one, ascends by one per beat and wraps to 0 inside the same row.
- R5: A write stores req_wdata into exactly one column; req_blen is ignored for writes and every other column keeps its value.
- R6: When a row closes, its bank is held in recovery. req_ready stays low for addresses in that bank for TRC cycles after the controller returns to idle, while addresses in the other bank are accepted as soon as the controller is idle.
- R7: req_ready is low for every address while a row access or a refresh is in progress.
- R8: A refresh becomes pending every REF_INT cycles counted from reset release. While one is pending, req_ready is low for all addresses. A refresh never splits a burst. It occupies three cycles (pending, open, write-back), after which its bank recovers for TRC cycles.
- R9: The refresh target is a counter of {row, bank} with the bank as its lowest bit, so successive refreshes alternate banks and rows ascend. Refresh leaves stored data unchanged.
- R10: Read beats return in request order and in column order, each carrying the word at its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle for the presented address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W+1 | {row, column, bank} start address |
| req_blen | input | 2 | Read burst length code (1 << code beats) |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read beat strobe |
| rd_data | output | DATA_W | Read beat data |

## Verification
A wrong recovery count or a wrong bank decode shows up at req_ready within a few cycles of a row closing. Either the other bank stays blocked, or the same bank is offered too early. The bench samples req_ready for both banks at every falling edge across such windows. A stale sense latch or a wrong column step corrupts rd_data on the very beat that uses it, four or more cycles after acceptance. A broken refresh timer or target counter moves the periodic ready gap by whole cycles, or leaves the wrong bank in recovery, and the bench compares a per-cycle ready map against the expected one over two refresh periods.

// File: rtl/dram_ilv_pkg.sv
package dram_ilv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_COL,
    ST_PRE,
    ST_RACT,
    ST_RWB
  } ctl_state_e;

  // Beat count for a burst length code: 1, 2, 4 or 8.
  function automatic logic [3:0] burst_beats(input logic [1:0] mode);
    return 4'(4'd1 << mode);
  endfunction

endpackage

// File: rtl/dram_ilv_bank.sv
module dram_ilv_bank #(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              we_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              close_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic [DATA_W-1:0] cells [ROWS][COLS];
  logic [DATA_W-1:0] sense [COLS];
  logic [ROW_W-1:0]  open_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          cells[r][c] <= '0;
        end
      end
      for (int c = 0; c < COLS; c++) begin
        sense[c] <= '0;
      end
      open_row <= '0;
    end else begin
      if (open_i) begin
        for (int c = 0; c < COLS; c++) begin
          sense[c] <= cells[row_i][c];
        end
        open_row <= row_i;
      end
      if (we_i) begin
        sense[col_i] <= wdata_i;
      end
      if (close_i) begin
        for (int c = 0; c < COLS; c++) begin
          cells[open_row][c] <= sense[c];
        end
      end
    end
  end

  assign rdata_o = sense[col_i];

endmodule

// File: rtl/dram_ilv_refresh.sv
module dram_ilv_refresh #(
  parameter int REF_INT = 1000,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  output logic             pend_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam int TMR_W = (REF_INT > 2) ? $clog2(REF_INT) : 1;

  logic [TMR_W-1:0] tmr;
  logic             tick;

  assign tick = (tmr == TMR_W'(REF_INT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr    <= '0;
      pend_o <= 1'b0;
      sel_o  <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (tick) begin
        pend_o <= 1'b1;
      end else if (take_i) begin
        pend_o <= 1'b0;
      end
      if (take_i) begin
        sel_o <= sel_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dram_ilv_rdpipe.sv
module dram_ilv_rdpipe #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [DEPTH-1:0]  vld;
  logic [DATA_W-1:0] dat [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int s = 0; s < DEPTH; s++) begin
        dat[s] <= '0;
      end
    end else begin
      vld[0] <= in_valid;
      dat[0] <= in_data;
      for (int s = 1; s < DEPTH; s++) begin
        vld[s] <= vld[s-1];
        dat[s] <= dat[s-1];
      end
    end
  end

  assign out_valid = vld[DEPTH-1];
  assign out_data  = dat[DEPTH-1];

endmodule

// File: rtl/dram_ilv_ctrl.sv
module dram_ilv_ctrl
  import dram_ilv_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3,
  parameter int TRC     = 4,
  parameter int RD_LAT  = 2,
  parameter int REF_INT = 1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ROW_W+COL_W:0]         req_addr,
  input  logic [1:0]                   req_blen,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         rd_valid,
  output logic [DATA_W-1:0]            rd_data
);
  localparam int ADDR_W    = ROW_W + COL_W + 1;
  localparam int REC_W     = $clog2(TRC + 1);
  localparam int REF_SEL_W = ROW_W + 1;

  function automatic logic addr_bank(input logic [ADDR_W-1:0] a);
    return a[0];
  endfunction

  function automatic logic [COL_W-1:0] addr_col(input logic [ADDR_W-1:0] a);
    return a[COL_W:1];
  endfunction

  function automatic logic [ROW_W-1:0] addr_row(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W+1];
  endfunction

  ctl_state_e         state;
  logic               cur_bank;
  logic [ROW_W-1:0]   cur_row;
  logic [COL_W-1:0]   cur_col;
  logic [3:0]         beats_left;
  logic               cur_wr;
  logic [DATA_W-1:0]  cur_wdata;

  // Named internal events
  logic                 accept;
  logic                 state_idle;
  logic                 act_pulse;
  logic                 col_sel;
  logic                 row_close;
  logic                 ref_active;
  logic                 ref_start;
  logic                 ref_pend;
  logic                 ref_bank;
  logic [REF_SEL_W-1:0] ref_sel;
  logic [1:0]           bank_busy;
  logic [DATA_W-1:0]    bank_rdata [2];
  logic                 rd_push;

  assign state_idle = (state == ST_IDLE);
  assign act_pulse  = (state == ST_ACT) || (state == ST_RACT);
  assign col_sel    = (state == ST_COL);
  assign row_close  = (state == ST_PRE) || (state == ST_RWB);
  assign ref_active = (state == ST_RACT) || (state == ST_RWB);
  assign ref_bank   = ref_sel[0];
  assign ref_start  = state_idle && ref_pend && !bank_busy[ref_bank];

  assign req_ready  = state_idle && !ref_pend && !bank_busy[addr_bank(req_addr)];
  assign accept     = req_valid && req_ready;
  assign rd_push    = col_sel && !cur_wr;

  // Banks with their recovery counters
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [REC_W-1:0] rec_cnt;
    logic             here;

    assign here = (cur_bank == 1'(b));

    dram_ilv_bank #(
      .DATA_W (DATA_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .open_i  (act_pulse && here),
      .row_i   (cur_row),
      .we_i    (col_sel && cur_wr && here),
      .col_i   (cur_col),
      .wdata_i (cur_wdata),
      .close_i (row_close && here),
      .rdata_o (bank_rdata[b])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rec_cnt <= '0;
      end else if (row_close && here) begin
        rec_cnt <= REC_W'(TRC);
      end else if (rec_cnt != '0) begin
        rec_cnt <= rec_cnt - 1'b1;
      end
    end

    assign bank_busy[b] = (rec_cnt != '0);
  end

  dram_ilv_refresh #(
    .REF_INT (REF_INT),
    .SEL_W   (REF_SEL_W)
  ) u_refresh (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (ref_start),
    .pend_o (ref_pend),
    .sel_o  (ref_sel)
  );

  dram_ilv_rdpipe #(
    .DATA_W (DATA_W),
    .DEPTH  (RD_LAT)
  ) u_rdpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rd_push),
    .in_data   (bank_rdata[cur_bank]),
    .out_valid (rd_valid),
    .out_data  (rd_data)
  );

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_bank   <= 1'b0;
      cur_row    <= '0;
      cur_col    <= '0;
      beats_left <= '0;
      cur_wr     <= 1'b0;
      cur_wdata  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ref_start) begin
            cur_bank <= ref_bank;
            cur_row  <= ref_sel[REF_SEL_W-1:1];
            state    <= ST_RACT;
          end else if (accept) begin
            cur_bank   <= addr_bank(req_addr);
            cur_row    <= addr_row(req_addr);
            cur_col    <= addr_col(req_addr);
            cur_wr     <= req_write;
            cur_wdata  <= req_wdata;
            beats_left <= req_write ? 4'd1 : burst_beats(req_blen);
            state      <= ST_ACT;
          end
        end
        ST_ACT:  state <= ST_COL;
        ST_COL: begin
          cur_col    <= cur_col + 1'b1;
          beats_left <= beats_left - 1'b1;
          if (beats_left == 4'd1) begin
            state <= ST_PRE;
          end
        end
        ST_PRE:  state <= ST_IDLE;
        ST_RACT: state <= ST_RWB;
        ST_RWB:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_ilv_chk.sv
module dram_ilv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       state_idle,
  input logic       act_pulse,
  input logic       col_sel,
  input logic       row_close,
  input logic       ref_active,
  input logic       ref_pend,
  input logic       ref_bank,
  input logic       cur_bank,
  input logic [1:0] bank_busy
);

  AST_ACCEPT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (act_pulse && !ref_active)); // R3

  AST_COL_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    col_sel |-> ($past(act_pulse) || $past(col_sel))); // R3

  AST_OPEN_BANK_RESTED: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |-> !bank_busy[cur_bank]); // R6

  AST_CLOSE_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    row_close |=> bank_busy[$past(cur_bank)]); // R6

  AST_CLOSE_AFTER_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (row_close && !ref_active) |-> $past(col_sel)); // R4

  AST_REF_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_idle && ref_pend && !bank_busy[ref_bank]) |=> ref_active); // R8

  AST_BUSY_NOT_ACCEPTING: assert property (@(posedge clk) disable iff (!rst_n)
    (col_sel || ref_active) |-> !accept); // R7

endmodule

bind dram_ilv_ctrl dram_ilv_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .state_idle (state_idle),
  .act_pulse  (act_pulse),
  .col_sel    (col_sel),
  .row_close  (row_close),
  .ref_active (ref_active),
  .ref_pend   (ref_pend),
  .ref_bank   (ref_bank),
  .cur_bank   (cur_bank),
  .bank_busy  (bank_busy)
);

// File: tb/test_dram_ilv_ctrl.sv
module test_dram_ilv_ctrl;
  localparam int DW   = 16;
  localparam int AW   = 7;
  localparam int TRC  = 4;
  localparam int RINT = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_blen = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW-1:0] mdl [128];

  always #4 clk = ~clk;

  dram_ilv_ctrl #(
    .DATA_W (DW), .ROW_W (3), .COL_W (3),
    .TRC (TRC), .RD_LAT (2), .REF_INT (RINT)
  ) i_dram_ilv_ctrl (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_write (req_write), .req_addr (req_addr), .req_blen (req_blen),
    .req_wdata (req_wdata), .rd_valid (rd_valid), .rd_data (rd_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    rst_n = 1'b1;
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int k);
    logic [2:0] c;
    c = 3'(a[3:1] + 3'(k));
    return {a[6:4], c, a[0]};
  endfunction

  // Sample ready for a given address without disturbing other inputs for long.
  task automatic peek_ready(input logic [AW-1:0] a, output logic r);
    req_addr = a;
    #1 r = req_ready;
  endtask

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [1:0] bl,
                        input logic [DW-1:0] wd, input int tag);
    int guard;
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_blen = bl; req_wdata = wd;
    #1;
    guard = 0;
    while (!req_ready && guard < 200) begin
      @(negedge clk);
      #1;
      guard++;
    end
    chk(req_ready, "R7 request eventually taken", 32'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      mdl[a] = wd;
      return;
    end
    n = 1 << bl;
    chk(!rd_valid, "R3 no beat one cycle after accept", 32'(rd_valid), 0);
    @(negedge clk);
    chk(!rd_valid, "R3 no beat two cycles after accept", 32'(rd_valid), 0);
    @(negedge clk);
    chk(!rd_valid, "R3 no beat three cycles after accept", 32'(rd_valid), 0);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(rd_valid, $sformatf("R%0d beat %0d valid", tag, k), 32'(rd_valid), 1);
      chk(rd_data == mdl[beat_addr(a, k)], $sformatf("R%0d beat %0d data", tag, k),
          32'(rd_data), 32'(mdl[beat_addr(a, k)]));
    end
    @(negedge clk);
    chk(!rd_valid, $sformatf("R%0d beat count %0d", tag, n), 32'(rd_valid), 0);
  endtask

  typedef struct packed {
    logic       wr;
    logic [1:0] bl;
    logic [6:0] addr;
    logic [15:0] wd;
    logic [3:0] tag;
  } vec_t;

  localparam vec_t [0:11] VECS = '{
    '{1'b1, 2'd0, 7'h00, 16'hA000, 4'd5},  // R5
    '{1'b1, 2'd0, 7'h01, 16'hB001, 4'd2},  // R2 same row/col, other bank
    '{1'b1, 2'd3, 7'h02, 16'hA011, 4'd5},  // R5 length code ignored
    '{1'b1, 2'd0, 7'h0E, 16'hA077, 4'd5},  // R5
    '{1'b0, 2'd1, 7'h0E, 16'h0000, 4'd4},  // R4 wraps column 7 -> 0
    '{1'b0, 2'd2, 7'h00, 16'h0000, 4'd4},  // R4 four beats
    '{1'b0, 2'd0, 7'h01, 16'h0000, 4'd2},  // R2 bank 1 word
    '{1'b1, 2'd0, 7'h35, 16'hC352, 4'd5},  // R5
    '{1'b0, 2'd3, 7'h31, 16'h0000, 4'd10}, // R10 eight beats in column order
    '{1'b0, 2'd0, 7'h02, 16'h0000, 4'd9},  // R9 data kept across refreshes
    '{1'b1, 2'd1, 7'h7F, 16'hFFFF, 4'd5},  // R5
    '{1'b0, 2'd0, 7'h7F, 16'h0000, 4'd10}  // R10
  };

  initial begin
    logic r0, r1;
    bit lo0 [1:110];
    bit lo1 [1:110];
    int bad0, bad1, first0, first1;

    // R1 reset state
    do_reset();
    peek_ready(7'h00, r0);
    peek_ready(7'h55, r1);
    chk(r0 && r1, "R1 ready after reset", {r0, r1}, 2'b11);
    chk(!rd_valid, "R1 no read strobe after reset", 32'(rd_valid), 0);

    // R8/R9 refresh timing over two periods with no traffic
    for (int k = 1; k <= 110; k++) begin
      @(negedge clk);
      peek_ready(7'h01, r1);
      peek_ready(7'h00, r0);
      lo1[k] = !r1;
      lo0[k] = !r0;
    end
    bad0 = 0; bad1 = 0; first0 = 0; first1 = 0;
    for (int k = 1; k <= 110; k++) begin
      bit e0, e1;
      e0 = (k >= RINT && k <= RINT + 2 + TRC) || (k >= 2*RINT && k <= 2*RINT + 2);
      e1 = (k >= RINT && k <= RINT + 2) || (k >= 2*RINT && k <= 2*RINT + 2 + TRC);
      if (lo0[k] != e0) begin bad0++; if (first0 == 0) first0 = k; end
      if (lo1[k] != e1) begin bad1++; if (first1 == 0) first1 = k; end
    end
    chk(bad0 == 0, "R8 bank0 ready map over refresh periods", 32'(first0), 0);
    chk(bad1 == 0, "R9 bank1 ready map shows alternating refresh target", 32'(first1), 0);

    // Table walk
    do_reset();
    peek_ready(7'h00, r0);
    chk(r0, "R1 ready before table", 32'(r0), 1);
    do_req(1'b0, 7'h24, 2'd3, '0, 1);  // R1 storage zero
    for (int i = 0; i < 12; i++) begin
      do_req(VECS[i].wr, VECS[i].addr, VECS[i].bl, VECS[i].wd, int'(VECS[i].tag));
    end

    // R6/R7 recovery versus interleave
    do_reset();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 7'h04; req_wdata = 16'h1234; req_blen = 2'd0;
    #1 chk(req_ready, "R6 ready for first write", 32'(req_ready), 1);
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;           // N1
    @(negedge clk);                              // N2
    @(negedge clk);                              // N3
    peek_ready(7'h05, r1);
    chk(!r1, "R7 busy while row closing", 32'(r1), 0);
    @(negedge clk);                              // N4
    peek_ready(7'h05, r1);
    peek_ready(7'h04, r0);
    chk(r1, "R6 other bank ready at idle", 32'(r1), 1);
    chk(!r0, "R6 same bank recovering", 32'(r0), 0);
    repeat (3) @(negedge clk);                   // N7
    peek_ready(7'h04, r0);
    chk(!r0, "R6 same bank still recovering", 32'(r0), 0);
    @(negedge clk);                              // N8
    peek_ready(7'h04, r0);
    chk(r0, "R6 same bank ready after recovery", 32'(r0), 1);

    // R8 refresh waits for a burst
    do_reset();
    repeat (RINT - 4) @(negedge clk);            // N46
    req_valid = 1'b1; req_write = 1'b0; req_addr = 7'h01; req_blen = 2'd3;
    #1 chk(req_ready, "R8 burst accepted before refresh", 32'(req_ready), 1);
    @(posedge clk);                              // P47
    @(negedge clk); req_valid = 1'b0;            // N47
    repeat (2) @(negedge clk);                   // N49
    begin
      int got;
      got = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);                          // N50..N57
        if (rd_valid) got++;
      end
      chk(got == 8, "R8 burst beats not split by refresh", 32'(got), 8);
    end
    peek_ready(7'h01, r1);                       // N57
    chk(!r1, "R8 ready low while refresh pending", 32'(r1), 0);
    repeat (4) @(negedge clk);                   // N61
    peek_ready(7'h01, r1);
    peek_ready(7'h00, r0);
    chk(r1, "R8 burst bank ready after refresh", 32'(r1), 1);
    chk(!r0, "R8 refreshed bank recovering", 32'(r0), 0);
    repeat (3) @(negedge clk);                   // N64
    peek_ready(7'h00, r0);
    chk(r0, "R8 refreshed bank ready again", 32'(r0), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule